// File: doc/BRIEF.md
# Ethernet Transmit Status Flag Tracker

This block follows one frame of a 10 Mb/s Ethernet MAC transmitter and keeps its status flags. The transmit engine gives it a strobe at each phase of the frame: the preamble begins, the frame delimiter begins, the last byte is sent, and the frame is finished. It also passes on carrier sense, collision and deferral events, the collision count, FIFO underrun, excessive deferral, the declared packet length and the stream of fragment lengths. The block keeps an eight-bit status word that the host can read at any time. It raises an abort request while a fatal condition is pending, and it gives a one-cycle valid pulse once the frame is finished.

A four-state machine tracks the phase of the frame. `ST_IDLE` goes to `ST_PREAMBLE` when the preamble starts; this is the new-frame transition. `ST_PREAMBLE` goes to `ST_WINDOW` on the delimiter strobe, and `ST_WINDOW` goes to `ST_TAIL` on the last-byte strobe. From any active state, a frame-done strobe returns the machine to `ST_IDLE`; this is the end transition, and it takes priority. Otherwise a preamble strobe returns it to `ST_PREAMBLE`; this is the retry transition, and it keeps the flags. A bit counter measures the time since the selected reference point, which is either the start of the preamble or the frame delimiter, and decides whether a collision is late. A length checker adds up the fragment lengths and compares the total with the declared length.

Top module: `txstat_tracker`

## Requirements
- R1: After reset, `status` is 0, `stat_valid` is 0 and `abort_req` is 0. The `status` bit positions are: 7 deferred, 6 no carrier, 5 carrier lost, 4 excessive collisions, 3 late collision, 2 underrun, 1 byte count mismatch, 0 sent OK.
- R2: A preamble strobe in `ST_IDLE` starts a new frame on the next cycle. All flags clear, except three: no-carrier is set, deferred takes the value of `attempt_deferred`, and carrier-lost is set when `loopback` is high. Carrier-lost stays set through a loopback frame.
- R3: Carrier sense is sampled only in `ST_WINDOW`, that is, from the cycle after the delimiter strobe through the cycle of the last-byte strobe. High carrier clears no-carrier and low carrier sets carrier-lost. Carrier values outside the window have no effect on the status.
- R4: If carrier never appears in the window, both no-carrier and carrier-lost end up set, and `abort_req` stays low.
- R5: While a frame is active, a `col_count` of 16 or more sets excessive collisions and also sets byte count mismatch.
- R6: A collision sets late collision when the bit counter is at 512 or more. The counter starts from 0 at each preamble strobe if `late_ref_sfd` is 0, or at the delimiter strobe if it is 1. It counts `bit_tick` pulses.
- R7: A collision clears the deferred flag.
- R8: On the fragment marked last, the declared length is compared with the sum of all fragment lengths of the frame. Any difference sets byte count mismatch.
- R9: Underrun while a frame is active sets the underrun flag.
- R10: At the frame-done strobe, sent OK is set only if none of these is pending: excessive collisions, excessive deferral, underrun, byte count mismatch.
- R11: `stat_valid` pulses for exactly one cycle, in the cycle after the frame-done strobe, and the machine returns to `ST_IDLE`.
- R12: `stat_ack` clears deferred and late collision and leaves every other flag unchanged.
- R13: `abort_req` is high from the cycle after excessive collisions, underrun or mismatch is flagged until the frame ends. It is low in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per transmitted bit time |
| pre_start | input | 1 | Preamble begins (new frame or retry) |
| sfd_start | input | 1 | Frame delimiter begins |
| last_byte | input | 1 | Last byte transmitted |
| frame_done | input | 1 | Frame finished |
| crs | input | 1 | Carrier sense |
| col_evt | input | 1 | Collision event pulse |
| col_count | input | COLCNT_W | Collisions so far in this frame |
| attempt_deferred | input | 1 | First attempt had to defer, sampled at new frame |
| exd_evt | input | 1 | Excessive deferral event |
| underrun | input | 1 | Transmit FIFO underrun |
| pkt_len | input | LEN_W | Declared packet length |
| frag_valid | input | 1 | Fragment length valid |
| frag_last | input | 1 | Marks the last fragment |
| frag_len | input | LEN_W | Fragment length |
| late_ref_sfd | input | 1 | 1: late-collision timing starts at the delimiter, 0: at the preamble |
| loopback | input | 1 | Loopback mode |
| stat_ack | input | 1 | Host acknowledge of the status write |
| status | output | 8 | Status flags |
| stat_valid | output | 1 | Status final (one-cycle pulse) |
| abort_req | output | 1 | Abort the transmission |

## Verification
The bench drives carrier sense low during the preamble and the tail. A design whose window was too wide would then set carrier-lost on frames that kept carrier the whole time. It places one collision at 480 bits after the delimiter but more than 512 bits after the preamble, and does so under both reference settings. A design that ignored the setting would flag this collision, or miss it, under the wrong setting. Other frames combine excessive collisions with a matching length, and excessive deferral with no flag set. A design that did not force the mismatch flag, or that computed sent OK from the visible flags only, would report the wrong word at the end of the frame. It also checks that carrier-lost stays set in loopback even with carrier present, and that an acknowledge leaves the other flags alone.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_WINDOW,
        ST_TAIL
    } tx_phase_e;

    // Bit 7 down to bit 0 of the status word.
    typedef struct packed {
        logic deferred;
        logic no_carrier;
        logic carrier_lost;
        logic excess_col;
        logic late_col;
        logic underrun;
        logic len_mismatch;
        logic sent_ok;
    } tx_flags_t;

endpackage

// File: rtl/txstat_phase_fsm.sv
module txstat_phase_fsm
    import txstat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pre_start,
    input  logic      sfd_start,
    input  logic      last_byte,
    input  logic      frame_done,
    output tx_phase_e phase,
    output logic      active,
    output logic      new_frame,
    output logic      attempt_start,
    output logic      sfd_seen,
    output logic      in_window,
    output logic      frame_end
);

    tx_phase_e phase_q, phase_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= ST_IDLE;
        else        phase_q <= phase_d;
    end

    // Next-state logic. Frame done wins over a retry, a retry wins over progress.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            ST_IDLE: begin
                if (pre_start) phase_d = ST_PREAMBLE;
            end
            ST_PREAMBLE: begin
                if (frame_done)     phase_d = ST_IDLE;
                else if (pre_start) phase_d = ST_PREAMBLE;
                else if (sfd_start) phase_d = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (frame_done)     phase_d = ST_IDLE;
                else if (pre_start) phase_d = ST_PREAMBLE;
                else if (last_byte) phase_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (frame_done)     phase_d = ST_IDLE;
                else if (pre_start) phase_d = ST_PREAMBLE;
            end
            default: phase_d = ST_IDLE;
        endcase
    end

    // Decoded outputs.
    always_comb begin
        phase         = phase_q;
        active        = (phase_q != ST_IDLE);
        new_frame     = (phase_q == ST_IDLE) && pre_start;
        attempt_start = pre_start && ((phase_q == ST_IDLE) || !frame_done);
        sfd_seen      = (phase_q == ST_PREAMBLE) && sfd_start && !frame_done && !pre_start;
        in_window     = (phase_q == ST_WINDOW);
        frame_end     = (phase_q != ST_IDLE) && frame_done;
    end

    // R11: leaving idle only goes to the preamble state.
    p_idle_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_IDLE) |=> (phase_q == ST_IDLE || phase_q == ST_PREAMBLE));

    // R3: the delimiter strobe opens the carrier window on the next cycle.
    p_sfd_opens_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sfd_seen |=> (phase_q == ST_WINDOW));

    // R11: frame end always returns to idle.
    p_end_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (phase_q == ST_IDLE));

endmodule

// File: rtl/txstat_bitclock.sv
module txstat_bitclock #(
    parameter int SLOT_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic use_sfd,
    input  logic ref_pre,
    input  logic ref_sfd,
    input  logic stop,
    output logic past_slot
);

    localparam int              CNT_W  = $clog2(SLOT_BITS + 1);
    localparam logic [CNT_W-1:0] SLOT_V = CNT_W'(SLOT_BITS);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             ref_hit;

    assign ref_hit = use_sfd ? ref_sfd : ref_pre;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (stop) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (ref_hit) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (use_sfd && ref_pre) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (run_q && bit_tick && (cnt_q < SLOT_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign past_slot = run_q && (cnt_q >= SLOT_V);

    // R6: once past the slot, it stays past until a new reference or the end of the frame.
    p_slot_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_slot && !stop && !ref_pre && !ref_sfd) |=> past_slot);

    // R6: a reference point restarts the count below the slot.
    p_ref_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && !stop) |=> !past_slot);

endmodule

// File: rtl/txstat_lencheck.sv
module txstat_lencheck #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAGS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             frag_valid,
    input  logic             frag_last,
    input  logic [LEN_W-1:0] frag_len,
    input  logic [LEN_W-1:0] pkt_len,
    output logic             mismatch
);

    localparam int SUM_W = LEN_W + $clog2(MAX_FRAGS + 1);

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_next;

    assign sum_next = sum_q + SUM_W'(frag_len);
    assign mismatch = active && frag_valid && frag_last && (sum_next != SUM_W'(pkt_len));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clear) begin
            sum_q <= '0;
        end else if (active && frag_valid) begin
            sum_q <= frag_last ? '0 : sum_next;
        end
    end

    // R8: a new frame starts the running sum from zero.
    p_sum_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum_q == '0));

endmodule

// File: rtl/txstat_tracker.sv
module txstat_tracker
    import txstat_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int SLOT_BITS = 512,
    parameter int COL_LIMIT = 16,
    parameter int COLCNT_W  = 5,
    parameter int MAX_FRAGS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                pre_start,
    input  logic                sfd_start,
    input  logic                last_byte,
    input  logic                frame_done,
    input  logic                crs,
    input  logic                col_evt,
    input  logic [COLCNT_W-1:0] col_count,
    input  logic                attempt_deferred,
    input  logic                exd_evt,
    input  logic                underrun,
    input  logic [LEN_W-1:0]    pkt_len,
    input  logic                frag_valid,
    input  logic                frag_last,
    input  logic [LEN_W-1:0]    frag_len,
    input  logic                late_ref_sfd,
    input  logic                loopback,
    input  logic                stat_ack,
    output logic [7:0]          status,
    output logic                stat_valid,
    output logic                abort_req
);

    localparam logic [COLCNT_W-1:0] COL_LIM_V = COLCNT_W'(COL_LIMIT);

    tx_phase_e phase;
    logic      active, new_frame, attempt_start, sfd_seen, in_window, frame_end;
    logic      past_slot, len_bad;
    tx_flags_t flags_q;
    logic      exd_q;
    logic      valid_q;
    logic      fatal;

    txstat_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pre_start    (pre_start),
        .sfd_start    (sfd_start),
        .last_byte    (last_byte),
        .frame_done   (frame_done),
        .phase        (phase),
        .active       (active),
        .new_frame    (new_frame),
        .attempt_start(attempt_start),
        .sfd_seen     (sfd_seen),
        .in_window    (in_window),
        .frame_end    (frame_end)
    );

    txstat_bitclock #(.SLOT_BITS(SLOT_BITS)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .use_sfd  (late_ref_sfd),
        .ref_pre  (attempt_start),
        .ref_sfd  (sfd_seen),
        .stop     (frame_end),
        .past_slot(past_slot)
    );

    txstat_lencheck #(.LEN_W(LEN_W), .MAX_FRAGS(MAX_FRAGS)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (new_frame),
        .active    (active),
        .frag_valid(frag_valid),
        .frag_last (frag_last),
        .frag_len  (frag_len),
        .pkt_len   (pkt_len),
        .mismatch  (len_bad)
    );

    assign fatal = flags_q.excess_col | flags_q.underrun | flags_q.len_mismatch;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            exd_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= frame_end;
            if (new_frame) begin
                flags_q              <= '0;
                flags_q.no_carrier   <= 1'b1;
                flags_q.carrier_lost <= loopback;
                flags_q.deferred     <= attempt_deferred;
                exd_q                <= 1'b0;
            end else begin
                if (active) begin
                    if (in_window) begin
                        if (crs) flags_q.no_carrier   <= 1'b0;
                        else     flags_q.carrier_lost <= 1'b1;
                    end
                    if (loopback) flags_q.carrier_lost <= 1'b1;
                    if (col_evt) begin
                        flags_q.deferred <= 1'b0;
                        if (past_slot) flags_q.late_col <= 1'b1;
                    end
                    if (col_count >= COL_LIM_V) begin
                        flags_q.excess_col   <= 1'b1;
                        flags_q.len_mismatch <= 1'b1;
                    end
                    if (underrun) flags_q.underrun     <= 1'b1;
                    if (len_bad)  flags_q.len_mismatch <= 1'b1;
                    if (exd_evt)  exd_q                <= 1'b1;
                end
                if (frame_end) flags_q.sent_ok <= !(fatal | exd_q);
                if (stat_ack) begin
                    flags_q.deferred <= 1'b0;
                    flags_q.late_col <= 1'b0;
                end
            end
        end
    end

    assign status     = flags_q;
    assign stat_valid = valid_q;
    assign abort_req  = active && fatal;

    // R2: a new frame shows no carrier and no sent OK on the next cycle.
    p_new_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        new_frame |=> (flags_q.no_carrier && !flags_q.sent_ok));

    // R4: carrier seen in the window clears no-carrier on the next cycle.
    p_carrier_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && crs) |=> !flags_q.no_carrier);

    // R5: excessive collisions always come with the mismatch flag.
    p_exc_forces_bcm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.excess_col |-> flags_q.len_mismatch);

    // R10: a fatal flag at frame end means no sent OK.
    p_no_ok_on_fatal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && fatal) |=> !flags_q.sent_ok);

    // R11: the valid pulse lasts one cycle.
    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    // R13: an abort request is held until the frame ends.
    p_abort_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && !frame_end) |=> abort_req);

    // R13: there is no abort request in idle.
    p_abort_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IDLE) |-> !abort_req);

endmodule

// File: tb/txstat_tracker_test.sv
module txstat_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b1;
    logic        pre_start = 0, sfd_start = 0, last_byte = 0, frame_done = 0;
    logic        crs = 0, col_evt = 0, attempt_deferred = 0, exd_evt = 0, underrun = 0;
    logic [4:0]  col_count = '0;
    logic [15:0] pkt_len = '0, frag_len = '0;
    logic        frag_valid = 0, frag_last = 0;
    logic        late_ref_sfd = 0, loopback = 0, stat_ack = 0;
    logic [7:0]  status;
    logic        stat_valid, abort_req;

    always #10 clk = ~clk;

    txstat_tracker uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .pre_start(pre_start),
        .sfd_start(sfd_start), .last_byte(last_byte), .frame_done(frame_done),
        .crs(crs), .col_evt(col_evt), .col_count(col_count),
        .attempt_deferred(attempt_deferred), .exd_evt(exd_evt), .underrun(underrun),
        .pkt_len(pkt_len), .frag_valid(frag_valid), .frag_last(frag_last),
        .frag_len(frag_len), .late_ref_sfd(late_ref_sfd), .loopback(loopback),
        .stat_ack(stat_ack), .status(status), .stat_valid(stat_valid),
        .abort_req(abort_req)
    );

    // Reference model state (bit positions follow R1).
    int         m_phase;   // 0 idle, 1 preamble, 2 window, 3 tail
    logic [7:0] m_st;
    logic       m_exd, m_sv, m_run;
    int         m_cnt, m_sum;
    int         n_cmp = 0, n_bad = 0;
    string      cur_req = "R1";
    bit         finished = 0;

    task automatic model_step();
        logic [7:0] n;
        bit act, fend, nf, att, sfdhit, past, mis;
        int np;
        if (!rst_n) begin
            m_phase = 0; m_st = '0; m_exd = 0; m_sv = 0; m_run = 0; m_cnt = 0; m_sum = 0;
            return;
        end
        act    = (m_phase != 0);
        fend   = act && frame_done;
        nf     = !act && pre_start;
        att    = pre_start && (!act || !frame_done);
        sfdhit = (m_phase == 1) && sfd_start && !frame_done && !pre_start;
        past   = m_run && (m_cnt >= 512);
        mis    = act && frag_valid && frag_last && ((m_sum + int'(frag_len)) != int'(pkt_len));
        n = m_st;
        if (nf) begin
            n = '0; n[6] = 1; n[5] = loopback; n[7] = attempt_deferred; m_exd = 0;
        end else begin
            if (act) begin
                if (m_phase == 2) begin
                    if (crs) n[6] = 0; else n[5] = 1;
                end
                if (loopback) n[5] = 1;
                if (col_evt) begin n[7] = 0; if (past) n[3] = 1; end
                if (col_count >= 16) begin n[4] = 1; n[1] = 1; end
                if (underrun) n[2] = 1;
                if (mis) n[1] = 1;
            end
            if (fend) n[0] = !(m_st[4] | m_exd | m_st[2] | m_st[1]);
            if (stat_ack) begin n[7] = 0; n[3] = 0; end
            if (act && exd_evt) m_exd = 1;
        end
        if (nf) m_sum = 0;
        else if (act && frag_valid) m_sum = frag_last ? 0 : m_sum + int'(frag_len);
        if (fend) begin m_run = 0; m_cnt = 0; end
        else if (late_ref_sfd ? sfdhit : att) begin m_run = 1; m_cnt = 0; end
        else if (late_ref_sfd && att) begin m_run = 0; m_cnt = 0; end
        else if (m_run && bit_tick && m_cnt < 512) m_cnt++;
        np = m_phase;
        if (m_phase == 0) begin if (pre_start) np = 1; end
        else if (frame_done) np = 0;
        else if (pre_start) np = 1;
        else if (m_phase == 1 && sfd_start) np = 2;
        else if (m_phase == 2 && last_byte) np = 3;
        m_phase = np;
        m_st = n;
        m_sv = fend;
    endtask

    task automatic compare();
        logic exp_ab;
        exp_ab = (m_phase != 0) && (m_st[4] | m_st[2] | m_st[1]);
        n_cmp++;
        if (status !== m_st || stat_valid !== m_sv || abort_req !== exp_ab) begin
            n_bad++;
            $display("FAIL %s: status=%b valid=%b abort=%b expected status=%b valid=%b abort=%b",
                     cur_req, status, stat_valid, abort_req, m_st, m_sv, exp_ab);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        repeat (n) cyc();
    endtask

    task automatic strobe_pre();  pre_start  = 1; cyc(); pre_start  = 0; endtask
    task automatic strobe_sfd();  sfd_start  = 1; cyc(); sfd_start  = 0; endtask
    task automatic strobe_last(); last_byte  = 1; cyc(); last_byte  = 0; endtask
    task automatic strobe_done(); frame_done = 1; cyc(); frame_done = 0; idle(2); endtask
    task automatic collide();     col_evt    = 1; cyc(); col_evt    = 0; endtask
    task automatic ack();         stat_ack   = 1; cyc(); stat_ack   = 0; endtask

    task automatic frag(logic [15:0] len, bit last);
        frag_valid = 1; frag_len = len; frag_last = last; cyc();
        frag_valid = 0; frag_last = 0;
    endtask

    // Default clean frame: carrier low in preamble and tail, high in window.
    task automatic clean_frame(int win);
        pkt_len = 16'd100;
        crs = 0; strobe_pre(); idle(8);
        frag(16'd60, 0); frag(16'd40, 1);
        strobe_sfd(); crs = 1; idle(win);
        strobe_last(); crs = 0; idle(3);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        idle(4);
        @(negedge clk); rst_n = 1;
        idle(3);

        // R3, R10, R11: clean frame, carrier only high inside window.
        cur_req = "R3";
        clean_frame(20);
        cur_req = "R11";
        strobe_done();

        // R4: carrier never seen.
        cur_req = "R4";
        pkt_len = 16'd50; strobe_pre(); idle(5); frag(16'd50, 1);
        strobe_sfd(); crs = 0; idle(15); strobe_last(); idle(2); strobe_done();

        // R3: carrier drops inside the window.
        cur_req = "R3";
        pkt_len = 16'd100; strobe_pre(); idle(4); frag(16'd100, 1);
        strobe_sfd(); crs = 1; idle(6); crs = 0; idle(2); crs = 1; idle(4);
        strobe_last(); crs = 0; strobe_done();

        // R7, R2: deferred then cleared by collision; R12: ack clears deferred.
        cur_req = "R7";
        attempt_deferred = 1; strobe_pre(); attempt_deferred = 0; idle(5);
        collide(); strobe_pre(); idle(3); strobe_sfd(); crs = 1; idle(5);
        strobe_last(); crs = 0; strobe_done();
        cur_req = "R12";
        attempt_deferred = 1; pkt_len = 16'd100; strobe_pre(); attempt_deferred = 0; idle(3);
        frag(16'd100, 1); ack(); idle(3); strobe_done();

        // R6: reference at preamble, late collision after 600 bits.
        cur_req = "R6";
        late_ref_sfd = 0; pkt_len = 16'd100; strobe_pre(); idle(64); frag(16'd100, 1);
        strobe_sfd(); crs = 1; idle(600); collide(); idle(4);
        cur_req = "R12";
        ack(); idle(3); strobe_last(); crs = 0; strobe_done();

        // R6: reference at delimiter, collision 480 bits after it (545 after preamble).
        cur_req = "R6";
        late_ref_sfd = 1; strobe_pre(); idle(64); frag(16'd100, 1);
        strobe_sfd(); crs = 1; idle(480); collide(); idle(4);
        strobe_last(); crs = 0; strobe_done();
        // Same setting, collision after the slot is flagged.
        strobe_pre(); idle(10); strobe_sfd(); crs = 1; idle(530); collide(); idle(3);
        strobe_last(); crs = 0; strobe_done();
        // Reference at preamble, same timing as the delimiter case: flagged.
        late_ref_sfd = 0;
        strobe_pre(); idle(64); strobe_sfd(); crs = 1; idle(480); collide(); idle(3);
        strobe_last(); crs = 0; strobe_done();

        // R5, R13: excessive collisions with a matching length.
        cur_req = "R5";
        pkt_len = 16'd100; strobe_pre(); idle(3); frag(16'd100, 1);
        col_count = 5'd15; idle(3); col_count = 5'd16; cyc(); col_count = 5'd0;
        cur_req = "R13";
        idle(6); strobe_done();

        // R8: fragment sum differs from declared length.
        cur_req = "R8";
        pkt_len = 16'd90; strobe_pre(); idle(3); frag(16'd60, 0); frag(16'd40, 1);
        idle(5); strobe_done();

        // R9: underrun.
        cur_req = "R9";
        pkt_len = 16'd100; strobe_pre(); idle(3); frag(16'd100, 1); strobe_sfd(); crs = 1;
        idle(4); underrun = 1; cyc(); underrun = 0; idle(4); crs = 0; strobe_done();

        // R10: excessive deferral blocks sent OK with no flag raised.
        cur_req = "R10";
        strobe_pre(); idle(3); frag(16'd100, 1); exd_evt = 1; cyc(); exd_evt = 0;
        strobe_sfd(); crs = 1; idle(5); strobe_last(); crs = 0; strobe_done();

        // R2: loopback keeps carrier-lost set even with carrier present.
        cur_req = "R2";
        loopback = 1; clean_frame(12); strobe_done(); loopback = 0;

        // R1: reset mid-frame returns everything to zero.
        cur_req = "R1";
        strobe_pre(); idle(3); underrun = 1; cyc(); underrun = 0; idle(2);
        rst_n = 0; idle(2); rst_n = 1; idle(3);
        cur_req = "R10";
        clean_frame(10); strobe_done();

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule